// File: doc/BRIEF.md
# Serial Bit Clock Generator with Trigger Timing Capture

This block derives the bit-timing clocks of one serial channel from a single 32-bit configuration word. It takes its input rate from one of three sources: a tick from an external fractional divider, a trigger pin, or the rising edges of a clock-select pin. An optional halving stage follows, then an integer divider. From this chain it produces a master clock and a shift clock, each with a configurable idle level. It also produces a tick for a downstream time-quanta counter from a selectable point in the chain.

The same chain feeds a saturating measurement counter. When measurement is on, either trigger stores the elapsed count, restarts the count and raises a one-cycle transmit shift event. Pins `trig1_async` and `sel1_async` may change at any time and are synchronized inside the block. `frac_tick` and `trig0` are single-cycle pulses in the `clk` domain. No output carries a data stream. Every output is a plain level or pulse with no back-pressure, so a consumer that misses a `shift_evt` pulse loses it.

Top module: `serial_bitclk_gen`

## Requirements
- R1: Bits 1:0 of the configuration word select the input tick. Code 0 uses `frac_tick`. Code 2 uses each rising edge of `trig1_async`, and code 3 each rising edge of `sel1_async`; both pins pass through a two-stage synchronizer and an edge detector first. Code 1 gives no input ticks.
- R2: The master clock level toggles on every input tick. For code 3 with halving off, it instead follows the synchronized `sel1_async` level. `mclk_out` is that level XOR bit 29, and the level is 0 after reset.
- R3: When bit 4 is set, a post-select tick occurs on every second input tick. When bit 4 is clear, every input tick is a post-select tick.
- R4: The divider factor F in bits 25:16 yields one divided tick per F+1 post-select ticks. The internal shift clock toggles on each divided tick and starts at 0.
- R5: `sclk_out` in internal mode is the shift clock XOR bit 30. When bit 31 is set, the shift clock seen at the output lags the undelayed one by exactly one `clk` cycle.
- R6: When bit 28 is set, `sclk_out` is `ext_sclk` XOR bit 30, and divided ticks have no effect on `sclk_out`.
- R7: With bit 3 set, a 10-bit counter adds one per post-select tick and holds at 1023.
- R8: With bit 3 set, a `trig0` pulse or a synchronized rising edge of `trig1_async` copies the counter to `meas_value`, clears the counter and pulses `shift_evt` high for the following cycle. A post-select tick in the same cycle as the trigger is not included in the copied value.
- R9: With bit 3 clear, the counter stays at 0, triggers leave `meas_value` unchanged and `shift_evt` stays low.
- R10: Bits 7:6 pick the quanta event: 0 divided tick, 1 post-select tick, 2 rising edge of the internal shift clock, 3 rising edge of the master clock level. With P in bits 9:8 and D in bits 14:10, `tq_tick` pulses once per (P+1)*(D+1) events.
- R11: After reset with an all-zero configuration word, `mclk_out`, `sclk_out`, `tq_tick`, `shift_evt` and `meas_value` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Configuration word; bits 2, 5, 15, 27:26 must be zero |
| frac_tick | input | 1 | Tick from the fractional divider |
| trig0 | input | 1 | Synchronous trigger pulse for measurement |
| trig1_async | input | 1 | Asynchronous trigger pin |
| sel1_async | input | 1 | Asynchronous clock-select pin |
| ext_sclk | input | 1 | Externally supplied transmit shift clock |
| mclk_out | output | 1 | Master clock |
| sclk_out | output | 1 | Shift clock |
| tq_tick | output | 1 | Time-quanta tick pulse |
| meas_value | output | MEAS_W | Last captured measurement |
| shift_evt | output | 1 | Transmit shift event pulse |

## Verification
The clock chain is driven with trains of fractional ticks, with slow trigger-pin pulses and with select-pin pulses. Toggle counts on both clocks separate the halving stage from the divider factor, and the reserved source code from a working one. Measurement runs with sparse ticks, with a tick colliding with a trigger, with back-to-back triggers and with a run long enough to saturate. These patterns separate correct capture, clearing, disabled and saturation behaviour. The quanta tests pair the selects with a divider factor or a pre-divider, so that each selected source produces a different pulse count.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int CFG_DIV_W = 10;
  localparam int CFG_PRE_W = 2;
  localparam int CFG_DEN_W = 5;

  typedef enum logic [1:0] {
    SRC_FRAC = 2'd0,
    SRC_NONE = 2'd1,
    SRC_TRIG = 2'd2,
    SRC_SEL  = 2'd3
  } src_sel_e;

  typedef enum logic [1:0] {
    QS_DIV  = 2'd0,
    QS_POST = 2'd1,
    QS_SCLK = 2'd2,
    QS_MCLK = 2'd3
  } q_sel_e;

  typedef struct packed {
    logic [1:0]           sclk_mode;   // [1] delay, [0] idle level
    logic                 mclk_idle;
    logic                 sclk_ext;
    logic [1:0]           rsv_hi;
    logic [CFG_DIV_W-1:0] div_factor;
    logic                 rsv_mid;
    logic [CFG_DEN_W-1:0] q_den;
    logic [CFG_PRE_W-1:0] q_pre;
    q_sel_e               q_sel;
    logic                 rsv_lo5;
    logic                 half_en;
    logic                 meas_en;
    logic                 rsv_lo2;
    src_sel_e             src;
  } cfg_t;
endpackage

// File: rtl/bcg_edge_sync.sv
module bcg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
      prev <= 1'b0;
    end else begin
      pipe <= {pipe[STAGES-2:0], raw};
      prev <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = lvl & ~prev;

  // R1
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/bcg_clk_chain.sv
module bcg_clk_chain #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic             half_en,
  input  logic             sel_follow,
  input  logic             sel_lvl,
  input  logic [DIV_W-1:0] div_factor,
  input  logic             sclk_delay,
  output logic             post_tick,
  output logic             div_tick,
  output logic             mclk_lvl,
  output logic             sclk_lvl,
  output logic             sclk_rise_evt
);
  logic             half_q;
  logic [DIV_W-1:0] div_cnt;
  logic             div_wrap;
  logic             sclk_q;
  logic             sclk_d;

  assign post_tick = src_tick & (~half_en | half_q);
  assign div_wrap  = (div_cnt >= div_factor);
  assign div_tick  = post_tick & div_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      div_cnt <= '0;
      sclk_q  <= 1'b0;
      sclk_d  <= 1'b0;
    end else begin
      if (src_tick) half_q <= ~half_q;
      if (post_tick) begin
        if (div_wrap) div_cnt <= '0;
        else          div_cnt <= div_cnt + 1'b1;
      end
      if (div_tick) sclk_q <= ~sclk_q;
      sclk_d <= sclk_q;
    end
  end

  assign mclk_lvl      = sel_follow ? sel_lvl : half_q;
  assign sclk_lvl      = sclk_delay ? sclk_d : sclk_q;
  assign sclk_rise_evt = div_tick & ~sclk_q;

  // R4
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_tick |=> $stable(sclk_q));
  // R4
  div_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> (div_cnt == '0));
endmodule

// File: rtl/bcg_meas.sv
module bcg_meas #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         step,
  input  logic         trig,
  output logic [W-1:0] cap,
  output logic         shift_evt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      cap       <= '0;
      shift_evt <= 1'b0;
    end else if (!en) begin
      cnt       <= '0;
      shift_evt <= 1'b0;
    end else if (trig) begin
      cap       <= cnt;
      cnt       <= '0;
      shift_evt <= 1'b1;
    end else begin
      shift_evt <= 1'b0;
      if (step && cnt != MAXV) cnt <= cnt + 1'b1;
    end
  end

  // R7
  meas_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !trig && cnt == MAXV) |=> (cnt == MAXV));
  // R8
  meas_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && trig) |=> (shift_evt && cap == $past(cnt)));
  // R9
  meas_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cap) && !shift_evt));
endmodule

// File: rtl/bcg_quanta.sv
module bcg_quanta #(
  parameter int PRE_W = 2,
  parameter int DEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [PRE_W-1:0] pre,
  input  logic [DEN_W-1:0] den,
  output logic             tq_tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [DEN_W-1:0] den_cnt;
  logic             pre_wrap;
  logic             den_wrap;

  assign pre_wrap = evt & (pre_cnt >= pre);
  assign den_wrap = pre_wrap & (den_cnt >= den);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      den_cnt <= '0;
      tq_tick <= 1'b0;
    end else begin
      if (evt) pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap) den_cnt <= den_wrap ? '0 : den_cnt + 1'b1;
      tq_tick <= den_wrap;
    end
  end

  // R10
  tq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tq_tick |-> $past(evt));
endmodule

// File: rtl/serial_bitclk_gen.sv
module serial_bitclk_gen
  import bcg_pkg::*;
#(
  parameter int MEAS_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic              frac_tick,
  input  logic              trig0,
  input  logic              trig1_async,
  input  logic              sel1_async,
  input  logic              ext_sclk,
  output logic              mclk_out,
  output logic              sclk_out,
  output logic              tq_tick,
  output logic [MEAS_W-1:0] meas_value,
  output logic              shift_evt
);
  localparam int NPINS = 2;
  localparam int PIN_TRIG = 0;
  localparam int PIN_SEL  = 1;

  cfg_t cfg;
  assign cfg = cfg_t'(cfg_word);

  logic [NPINS-1:0] pin_raw, pin_lvl, pin_rise;
  assign pin_raw = {sel1_async, trig1_async};

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    bcg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (pin_raw[g]),
      .lvl  (pin_lvl[g]),
      .rise (pin_rise[g])
    );
  end

  logic src_tick;
  always_comb begin
    case (cfg.src)
      SRC_FRAC: src_tick = frac_tick;
      SRC_TRIG: src_tick = pin_rise[PIN_TRIG];
      SRC_SEL:  src_tick = pin_rise[PIN_SEL];
      default:  src_tick = 1'b0;
    endcase
  end

  logic post_tick, div_tick, mclk_lvl, sclk_lvl, sclk_rise_evt;
  logic sel_follow;
  assign sel_follow = (cfg.src == SRC_SEL) && !cfg.half_en;

  bcg_clk_chain #(.DIV_W(CFG_DIV_W)) u_chain (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_tick     (src_tick),
    .half_en      (cfg.half_en),
    .sel_follow   (sel_follow),
    .sel_lvl      (pin_lvl[PIN_SEL]),
    .div_factor   (cfg.div_factor),
    .sclk_delay   (cfg.sclk_mode[1]),
    .post_tick    (post_tick),
    .div_tick     (div_tick),
    .mclk_lvl     (mclk_lvl),
    .sclk_lvl     (sclk_lvl),
    .sclk_rise_evt(sclk_rise_evt)
  );

  logic mclk_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mclk_prev <= 1'b0;
    else        mclk_prev <= mclk_lvl;
  end

  logic q_evt;
  always_comb begin
    case (cfg.q_sel)
      QS_DIV:  q_evt = div_tick;
      QS_POST: q_evt = post_tick;
      QS_SCLK: q_evt = sclk_rise_evt;
      default: q_evt = mclk_lvl & ~mclk_prev;
    endcase
  end

  bcg_quanta #(.PRE_W(CFG_PRE_W), .DEN_W(CFG_DEN_W)) u_quanta (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (q_evt),
    .pre    (cfg.q_pre),
    .den    (cfg.q_den),
    .tq_tick(tq_tick)
  );

  bcg_meas #(.W(MEAS_W)) u_meas (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg.meas_en),
    .step     (post_tick),
    .trig     (trig0 | pin_rise[PIN_TRIG]),
    .cap      (meas_value),
    .shift_evt(shift_evt)
  );

  assign mclk_out = mclk_lvl ^ cfg.mclk_idle;
  assign sclk_out = (cfg.sclk_ext ? ext_sclk : sclk_lvl) ^ cfg.sclk_mode[0];

  cfg_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.rsv_hi == 2'b00) && !cfg.rsv_mid && !cfg.rsv_lo5 && !cfg.rsv_lo2);
endmodule

// File: tb/serial_bitclk_gen_test.sv
module serial_bitclk_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        frac_tick = 1'b0, trig0 = 1'b0, trig1_async = 1'b0;
  logic        sel1_async = 1'b0, ext_sclk = 1'b0;
  logic        mclk_out, sclk_out, tq_tick, shift_evt;
  logic [9:0]  meas_value;

  int n_chk = 0, n_fail = 0;
  int sclk_tg = 0, mclk_tg = 0, tq_n = 0, evt_n = 0;
  logic sclk_p = 1'b0, mclk_p = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  serial_bitclk_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .frac_tick(frac_tick),
    .trig0(trig0), .trig1_async(trig1_async), .sel1_async(sel1_async),
    .ext_sclk(ext_sclk), .mclk_out(mclk_out), .sclk_out(sclk_out),
    .tq_tick(tq_tick), .meas_value(meas_value), .shift_evt(shift_evt)
  );

  always @(negedge clk) begin
    if (sclk_out !== sclk_p) sclk_tg++;
    if (mclk_out !== mclk_p) mclk_tg++;
    if (tq_tick) tq_n++;
    if (shift_evt) evt_n++;
    sclk_p = sclk_out;
    mclk_p = mclk_out;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    sclk_tg = 0; mclk_tg = 0; tq_n = 0; evt_n = 0;
  endtask

  task automatic do_reset(input logic [31:0] cfg);
    @(negedge clk);
    rst_n = 1'b0; cfg_word = cfg;
    frac_tick = 0; trig0 = 0; trig1_async = 0; sel1_async = 0; ext_sclk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    clear_counts();
  endtask

  task automatic fracs(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frac_tick = 1'b1;
      @(negedge clk) frac_tick = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pin_pulses(input int n, input bit sel);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sel) sel1_async = 1'b1; else trig1_async = 1'b1;
      repeat (3) @(negedge clk);
      if (sel) sel1_async = 1'b0; else trig1_async = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_trig0();
    @(negedge clk) trig0 = 1'b1;
    @(negedge clk) trig0 = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset_idle();
    do_reset(32'h0);
    check("R11 mclk", mclk_out, 0);
    check("R11 sclk", sclk_out, 0);
    check("R11 tq", tq_tick, 0);
    check("R11 evt", shift_evt, 0);
    check("R11 meas", meas_value, 0);
    cfg_word = 32'h6000_0000;
    @(negedge clk);
    check("R2 mclk idle 1", mclk_out, 1);
    check("R5 sclk idle 1", sclk_out, 1);
  endtask

  task automatic t_divider();
    do_reset(32'h0003_0000);
    fracs(16);
    check("R4 sclk toggles F=3", sclk_tg, 4);
    check("R2 mclk toggles", mclk_tg, 16);
    do_reset(32'h0000_0000);
    fracs(5);
    check("R4 sclk toggles F=0", sclk_tg, 5);
  endtask

  task automatic t_half();
    do_reset(32'h0001_0010);
    fracs(16);
    check("R3 sclk toggles halved", sclk_tg, 4);
    check("R3 mclk toggles halved", mclk_tg, 16);
  endtask

  task automatic t_trig_src();
    do_reset(32'h0001_0002);
    pin_pulses(6, 1'b0);
    check("R1 trig src mclk", mclk_tg, 6);
    check("R1 trig src sclk", sclk_tg, 3);
    check("R9 no evt when off", evt_n, 0);
    check("R9 meas unchanged", meas_value, 0);
  endtask

  task automatic t_sel_src();
    do_reset(32'h0000_0003);
    @(negedge clk) sel1_async = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 mclk follows sel high", mclk_out, 1);
    sel1_async = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 mclk follows sel low", mclk_out, 0);
    clear_counts();
    pin_pulses(4, 1'b1);
    check("R1 sel src sclk", sclk_tg, 4);
    check("R2 sel src mclk", mclk_tg, 8);
  endtask

  task automatic t_reserved_src();
    do_reset(32'h0000_0001);
    fracs(10);
    check("R1 code1 sclk", sclk_tg, 0);
    check("R1 code1 mclk", mclk_tg, 0);
  endtask

  task automatic t_delay();
    do_reset(32'h0);
    @(negedge clk) frac_tick = 1'b1;
    @(negedge clk) frac_tick = 1'b0;
    check("R5 undelayed edge", sclk_out, 1);
    do_reset(32'h8000_0000);
    @(negedge clk) frac_tick = 1'b1;
    @(negedge clk) frac_tick = 1'b0;
    check("R5 delayed not yet", sclk_out, 0);
    @(negedge clk);
    check("R5 delayed one cycle", sclk_out, 1);
  endtask

  task automatic t_ext();
    do_reset(32'h1000_0000);
    @(negedge clk) ext_sclk = 1'b1;
    @(negedge clk);
    check("R6 ext high", sclk_out, 1);
    ext_sclk = 1'b0;
    @(negedge clk);
    clear_counts();
    fracs(4);
    check("R6 ticks ignored", sclk_tg, 0);
    cfg_word = 32'h5000_0000;
    @(negedge clk);
    check("R6 ext inverted", sclk_out, 1);
  endtask

  task automatic t_meas();
    do_reset(32'h0000_0008);
    fracs(5);
    pulse_trig0();
    check("R8 capture 5", meas_value, 5);
    check("R8 one event", evt_n, 1);
    fracs(2);
    pulse_trig0();
    check("R8 capture after clear", meas_value, 2);
    fracs(2);
    @(negedge clk) begin frac_tick = 1'b1; trig0 = 1'b1; end
    @(negedge clk) begin frac_tick = 1'b0; trig0 = 1'b0; end
    @(negedge clk);
    check("R8 same-cycle tick excluded", meas_value, 2);
    pulse_trig0();
    check("R8 back-to-back zero", meas_value, 0);
    fracs(4);
    pin_pulses(1, 1'b0);
    check("R8 trig1 capture", meas_value, 4);
    check("R8 event count", evt_n, 5);
    @(negedge clk) frac_tick = 1'b1;
    repeat (1100) @(negedge clk);
    frac_tick = 1'b0;
    pulse_trig0();
    check("R7 saturation", meas_value, 1023);
  endtask

  task automatic t_meas_off();
    do_reset(32'h0000_0008);
    fracs(3);
    pulse_trig0();
    check("R8 capture 3", meas_value, 3);
    cfg_word = 32'h0;
    clear_counts();
    fracs(5);
    pulse_trig0();
    pin_pulses(1, 1'b0);
    check("R9 meas held", meas_value, 3);
    check("R9 no event", evt_n, 0);
  endtask

  task automatic t_quanta();
    do_reset(32'h0000_0940);
    fracs(18);
    check("R10 post src pre1 den2", tq_n, 3);
    do_reset(32'h0000_0080);
    fracs(8);
    check("R10 sclk rise src", tq_n, 4);
    do_reset(32'h0000_00C0);
    fracs(8);
    check("R10 mclk rise src", tq_n, 4);
    do_reset(32'h0001_0000);
    fracs(8);
    check("R10 div src F=1", tq_n, 4);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset_idle();
    t_divider();
    t_half();
    t_trig_src();
    t_sel_src();
    t_reserved_src();
    t_delay();
    t_ext();
    t_meas();
    t_meas_off();
    t_quanta();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule